// File: doc/BRIEF.md
# Standby Power-Down Sequencer

This block steps a processor subsystem into and out of its deepest low-power state. A one-cycle standby command starts the entry handshake. The sequencer first waits until the system bus reports no transfer in flight. It then asks the cache to write back and invalidate its contents and waits for the cache to confirm. Next it puts the internal memory into self-refresh. Only after that does it drop the clock-generator enable and pull the active-low standby status output low. In that stopped state the only way out, apart from reset, is the wakeup input.

Leaving standby runs the entry steps in reverse. The clock enable comes back first. A fixed lock interval of `LOCK_CYC` cycles follows. Then self-refresh is released and the standby status returns high. One cycle later a single-cycle wakeup interrupt tells the processor it is running again. A lighter sleep mode is also available: it gates only the core clock and leaves the clock generator, the memory and the status output alone.

The wakeup and reset inputs may change at any time relative to the clock. Each one passes through its own two-flop synchronizer. The synchronized reset is used as a synchronous reset for all state, and it wins over every other condition.

Top module: `stby_seq`

## Requirements
- R1: Reset is synchronized through two flops and takes effect on the third rising edge after `rst_n` falls, from any state. Under reset the outputs are `purge_req`=0, `selfref_en`=0, `clk_en`=1, `core_clk_en`=1, `stby_n`=1 and `wake_irq`=0.
- R2: After `stby_cmd`, `purge_req` stays low for as long as `bus_idle` is low. It goes high in the cycle after `bus_idle` is sampled high.
- R3: `purge_req` stays high until `purge_done` is sampled high. In the following cycle `purge_req` falls and `selfref_en` rises, while `clk_en` and `stby_n` are still high.
- R4: One cycle after `selfref_en` rises, `clk_en`, `core_clk_en` and `stby_n` all go low. `clk_en` is never low unless `selfref_en` is high.
- R5: `wake_req` passes through two synchronizer flops. When it is raised in the stopped state, `clk_en` returns high on the third rising edge. In every other state `wake_req` has no effect: no interrupt is raised and the status output does not change.
- R6: After wakeup, `clk_en` is high and `selfref_en` stays high for exactly `LOCK_CYC` cycles. After that, `selfref_en` falls.
- R7: `selfref_en` falls while `stby_n` is still low. `stby_n` rises in the next cycle. `wake_irq` is high for exactly one cycle, in the cycle after that, and normal running then resumes.
- R8: When `sleep_cmd` is high while running, `core_clk_en` goes low in the next cycle. `clk_en`, `selfref_en` and `stby_n` stay at their running values. `core_clk_en` returns high in the cycle after `sleep_cmd` is sampled low.
- R9: When `stby_cmd` and `sleep_cmd` are high together, the standby entry sequence starts and the core clock is not gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset request, synchronized internally |
| stby_cmd | input | 1 | One-cycle request to enter standby |
| sleep_cmd | input | 1 | Level request for core-clock sleep |
| bus_idle | input | 1 | High when no bus transfer is in progress |
| purge_done | input | 1 | Cache reports that the purge has completed |
| wake_req | input | 1 | Asynchronous wakeup request |
| purge_req | output | 1 | Asks the cache to purge |
| selfref_en | output | 1 | Places the internal memory in self-refresh |
| clk_en | output | 1 | Enables the clock generator and all clocks |
| core_clk_en | output | 1 | Enables the processor core clock |
| stby_n | output | 1 | Low while in standby |
| wake_irq | output | 1 | One-cycle wakeup interrupt |

## Verification
On every cycle the assertions check the ordering rules between neighbouring steps. Purge may only start after the bus has been seen idle. Self-refresh may only start after a purge request. The clock may only be off while the memory is in self-refresh. Status may only return high once self-refresh has ended, and the interrupt is a single-cycle pulse that follows the status change.

Some properties can only be shown by the bench's scenarios. These are the exact synchronizer latencies for reset and wakeup, the length of the lock interval, the fact that wakeup is ignored outside the stopped state, and the sleep behaviour. The bench sweeps every combination of bus-drain and purge delays from zero to three cycles and checks each phase boundary at the cycle where it is expected.

// File: rtl/stby_pkg.sv
// Shared types for the standby sequencer.
// Assumes: one clock domain; the state encoding is internal only.
package stby_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_SLEEP,
        ST_DRAIN,
        ST_PURGE,
        ST_SREF_ON,
        ST_HALT,
        ST_LOCK,
        ST_SREF_OFF,
        ST_RELEASE,
        ST_WAKE
    } seq_state_t;

endpackage

// File: rtl/stby_sync.sv
// Multi-flop synchronizer for a single-bit asynchronous input.
// Assumes: STAGES >= 2; rst_n is already synchronous to clk (or a constant).
module stby_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/stby_lock_timer.sv
// Down-counter that measures the clock-lock interval after wakeup.
// A start pulse loads it. done is high once LOCK_CYC cycles have passed since start.
// Assumes: LOCK_CYC >= 1.
module stby_lock_timer #(
    parameter int LOCK_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= CW'(LOCK_CYC - 1);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0) && !start;

endmodule

// File: rtl/stby_fsm.sv
// Control state machine for standby entry, stop, exit and core sleep.
// Assumes: the wake input is already synchronized; lock_done comes from stby_lock_timer.
module stby_fsm
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_cmd,
    input  logic       sleep_cmd,
    input  logic       bus_idle,
    input  logic       purge_done,
    input  logic       wake_s,
    input  logic       lock_done,
    output seq_state_t state,
    output logic       lock_start
);

    seq_state_t nxt;

    // Next-state selection; standby requests win over sleep.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (stby_cmd) nxt = ST_DRAIN;
                         else if (sleep_cmd) nxt = ST_SLEEP;
            ST_SLEEP:    if (stby_cmd) nxt = ST_DRAIN;
                         else if (!sleep_cmd) nxt = ST_RUN;
            ST_DRAIN:    if (bus_idle) nxt = ST_PURGE;
            ST_PURGE:    if (purge_done) nxt = ST_SREF_ON;
            ST_SREF_ON:  nxt = ST_HALT;
            ST_HALT:     if (wake_s) nxt = ST_LOCK;
            ST_LOCK:     if (lock_done) nxt = ST_SREF_OFF;
            ST_SREF_OFF: nxt = ST_RELEASE;
            ST_RELEASE:  nxt = ST_WAKE;
            ST_WAKE:     nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    assign lock_start = (state == ST_HALT) && wake_s;

endmodule

// File: rtl/stby_seq.sv
// Top level of the standby power-down sequencer.
// It synchronizes reset and wakeup, runs the control FSM and lock timer,
// and decodes the power-control outputs from the current state.
// Assumes: rst_n and wake_req are asynchronous; all other inputs are synchronous to clk.
module stby_seq
    import stby_pkg::*;
#(
    parameter int LOCK_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_cmd,
    input  logic sleep_cmd,
    input  logic bus_idle,
    input  logic purge_done,
    input  logic wake_req,
    output logic purge_req,
    output logic selfref_en,
    output logic clk_en,
    output logic core_clk_en,
    output logic stby_n,
    output logic wake_irq
);

    logic       rst_q_n;
    logic       wake_s;
    logic       lock_start;
    logic       lock_done;
    seq_state_t state;

    stby_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk   (clk),
        .rst_n (1'b1),
        .d     (rst_n),
        .q     (rst_q_n)
    );

    stby_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
        .clk   (clk),
        .rst_n (rst_q_n),
        .d     (wake_req),
        .q     (wake_s)
    );

    stby_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_q_n),
        .start (lock_start),
        .done  (lock_done)
    );

    stby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_q_n),
        .stby_cmd   (stby_cmd),
        .sleep_cmd  (sleep_cmd),
        .bus_idle   (bus_idle),
        .purge_done (purge_done),
        .wake_s     (wake_s),
        .lock_done  (lock_done),
        .state      (state),
        .lock_start (lock_start)
    );

    // Decode the power-control outputs from the state.
    always_comb begin
        purge_req   = 1'b0;
        selfref_en  = 1'b0;
        clk_en      = 1'b1;
        core_clk_en = 1'b1;
        stby_n      = 1'b1;
        wake_irq    = 1'b0;
        unique case (state)
            ST_SLEEP:    core_clk_en = 1'b0;
            ST_PURGE:    purge_req   = 1'b1;
            ST_SREF_ON:  selfref_en  = 1'b1;
            ST_HALT: begin
                selfref_en  = 1'b1;
                clk_en      = 1'b0;
                core_clk_en = 1'b0;
                stby_n      = 1'b0;
            end
            ST_LOCK: begin
                selfref_en  = 1'b1;
                core_clk_en = 1'b0;
                stby_n      = 1'b0;
            end
            ST_SREF_OFF: stby_n      = 1'b0;
            ST_WAKE:     wake_irq    = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/stby_seq_checker.sv
// Ordering properties for stby_seq, bound to the top level.
// Assumes: rst_n is the synchronized reset taken from inside the top.
module stby_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_idle,
    input logic purge_req,
    input logic selfref_en,
    input logic clk_en,
    input logic core_clk_en,
    input logic stby_n,
    input logic wake_irq
);

    a_r2_purge_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(purge_req) |-> $past(bus_idle));

    a_r3_sref_after_purge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selfref_en) |-> $past(purge_req));

    a_r4_clk_off_in_sref: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> selfref_en);

    a_r4_status_low_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stby_n) |-> !clk_en);

    a_r6_sref_off_clocked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(selfref_en) |-> clk_en);

    a_r7_status_after_sref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stby_n) |-> !selfref_en);

    a_r7_irq_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (stby_n && $past(stby_n)));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    a_r8_sleep_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && stby_n) |-> (clk_en && !selfref_en));

endmodule

bind stby_seq stby_seq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .bus_idle    (bus_idle),
    .purge_req   (purge_req),
    .selfref_en  (selfref_en),
    .clk_en      (clk_en),
    .core_clk_en (core_clk_en),
    .stby_n      (stby_n),
    .wake_irq    (wake_irq)
);

// File: tb/stby_seq_bench.sv
// Self-checking bench: sweeps the bus-drain and purge delays, then covers
// reset override, ignored wakeups, sleep and standby/sleep priority.
module stby_seq_bench;

    localparam int LOCK = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_cmd = 1'b0;
    logic sleep_cmd = 1'b0;
    logic bus_idle = 1'b0;
    logic purge_done = 1'b0;
    logic wake_req = 1'b0;
    logic purge_req, selfref_en, clk_en, core_clk_en, stby_n, wake_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    stby_seq #(.LOCK_CYC(LOCK), .SYNC_STAGES(2)) u_stby_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stby_cmd    (stby_cmd),
        .sleep_cmd   (sleep_cmd),
        .bus_idle    (bus_idle),
        .purge_done  (purge_done),
        .wake_req    (wake_req),
        .purge_req   (purge_req),
        .selfref_en  (selfref_en),
        .clk_en      (clk_en),
        .core_clk_en (core_clk_en),
        .stby_n      (stby_n),
        .wake_irq    (wake_irq)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_outputs(input string tag);
        chk(purge_req, 1'b0, {tag, " purge_req"});
        chk(selfref_en, 1'b0, {tag, " selfref_en"});
        chk(clk_en, 1'b1, {tag, " clk_en"});
        chk(core_clk_en, 1'b1, {tag, " core_clk_en"});
        chk(stby_n, 1'b1, {tag, " stby_n"});
        chk(wake_irq, 1'b0, {tag, " wake_irq"});
    endtask

    // Drive the entry sequence with d cycles of busy bus and p cycles of purge.
    task automatic enter(input int d, input int p);
        stby_cmd = 1'b1;
        step();
        stby_cmd = 1'b0;
        for (int i = 0; i < d; i++) begin
            chk(purge_req, 1'b0, "R2 purge held while bus busy");
            step();
        end
        bus_idle = 1'b1;
        step();
        bus_idle = 1'b0;
        chk(purge_req, 1'b1, "R2 purge after idle");
        chk(selfref_en, 1'b0, "R3 no sref before purge done");
        for (int i = 0; i < p; i++) begin
            step();
            chk(purge_req, 1'b1, "R3 purge held");
            chk(selfref_en, 1'b0, "R3 sref waits");
        end
        purge_done = 1'b1;
        step();
        purge_done = 1'b0;
        chk(selfref_en, 1'b1, "R3 sref on");
        chk(purge_req, 1'b0, "R3 purge drop");
        chk(clk_en, 1'b1, "R3 clk still on");
        chk(stby_n, 1'b1, "R3 status still high");
        step();
        chk(clk_en, 1'b0, "R4 clk off");
        chk(core_clk_en, 1'b0, "R4 core off");
        chk(stby_n, 1'b0, "R4 status low");
        chk(selfref_en, 1'b1, "R4 sref held");
    endtask

    // Drive the wakeup and check the exit order.
    task automatic leave();
        wake_req = 1'b1;
        step();
        chk(clk_en, 1'b0, "R5 sync stage 1");
        step();
        chk(clk_en, 1'b0, "R5 sync stage 2");
        step();
        wake_req = 1'b0;
        chk(clk_en, 1'b1, "R5 clk back on third edge");
        chk(selfref_en, 1'b1, "R6 sref held at lock start");
        for (int i = 1; i < LOCK; i++) begin
            step();
            chk(selfref_en, 1'b1, "R6 sref held during lock");
            chk(clk_en, 1'b1, "R6 clk on during lock");
        end
        step();
        chk(selfref_en, 1'b0, "R6 sref off after lock");
        chk(stby_n, 1'b0, "R7 status low as sref drops");
        step();
        chk(stby_n, 1'b1, "R7 status high");
        chk(wake_irq, 1'b0, "R7 irq after status");
        step();
        chk(wake_irq, 1'b1, "R7 irq pulse");
        step();
        chk(wake_irq, 1'b0, "R7 irq one cycle");
        run_outputs("R7 running again");
    endtask

    initial begin
        step();
        repeat (5) step();
        rst_n = 1'b1;
        repeat (3) step();
        run_outputs("R1 reset state");

        // Sweep drain and purge delays.
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 4; p++) begin
                enter(d, p);
                repeat (d + p) begin
                    step();
                    chk(clk_en, 1'b0, "R5 stays stopped without wake");
                end
                leave();
                step();
            end
        end

        // Wake ignored while running.
        wake_req = 1'b1;
        repeat (6) begin
            step();
            chk(wake_irq, 1'b0, "R5 wake ignored in run");
            chk(stby_n, 1'b1, "R5 status unchanged in run");
        end
        wake_req = 1'b0;
        repeat (3) step();

        // Sleep mode.
        sleep_cmd = 1'b1;
        step();
        chk(core_clk_en, 1'b0, "R8 core gated");
        chk(clk_en, 1'b1, "R8 clk kept");
        chk(stby_n, 1'b1, "R8 status kept");
        chk(selfref_en, 1'b0, "R8 no sref");
        wake_req = 1'b1;
        repeat (5) begin
            step();
            chk(wake_irq, 1'b0, "R5 wake ignored in sleep");
            chk(core_clk_en, 1'b0, "R8 core stays gated");
        end
        wake_req = 1'b0;
        repeat (3) step();
        sleep_cmd = 1'b0;
        step();
        chk(core_clk_en, 1'b1, "R8 core restored");

        // Standby wins over sleep.
        sleep_cmd = 1'b1;
        stby_cmd = 1'b1;
        step();
        stby_cmd = 1'b0;
        sleep_cmd = 1'b0;
        chk(core_clk_en, 1'b1, "R9 core not gated");
        chk(purge_req, 1'b0, "R9 in drain");
        bus_idle = 1'b1;
        step();
        bus_idle = 1'b0;
        chk(purge_req, 1'b1, "R9 standby sequence runs");
        purge_done = 1'b1;
        step();
        purge_done = 1'b0;
        step();
        chk(stby_n, 1'b0, "R9 standby reached");

        // Reset overrides the stopped state.
        rst_n = 1'b0;
        step();
        chk(clk_en, 1'b0, "R1 reset sync stage 1");
        step();
        chk(clk_en, 1'b0, "R1 reset sync stage 2");
        step();
        run_outputs("R1 reset from standby");
        rst_n = 1'b1;
        repeat (3) step();

        // Reset overrides an open purge.
        stby_cmd = 1'b1;
        bus_idle = 1'b1;
        step();
        stby_cmd = 1'b0;
        step();
        bus_idle = 1'b0;
        chk(purge_req, 1'b1, "R1 purge open before reset");
        rst_n = 1'b0;
        repeat (3) step();
        run_outputs("R1 reset from purge");
        rst_n = 1'b1;
        repeat (3) step();

        // Reset overrides sleep.
        sleep_cmd = 1'b1;
        step();
        chk(core_clk_en, 1'b0, "R8 sleep before reset");
        rst_n = 1'b0;
        repeat (3) step();
        run_outputs("R1 reset from sleep");
        sleep_cmd = 1'b0;
        rst_n = 1'b1;
        repeat (3) step();
        run_outputs("R1 after release");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule